// File: doc/BRIEF.md
# Programmable-Domain Configuration Clear Controller

This block decides when the configuration of a programmable-logic domain is wiped, based on reset signals that come from a neighbouring processor domain. It watches three active-low inputs: a power-on reset, a system reset and a direct clear request. It also watches two level controls: a trigger enable for the system reset, and a processor-only mode bit. All five inputs are brought onto the block clock through synchronisers. Edges are then detected on the clean copies.

The two processor resets start a clear only when they are released, on their low-to-high transition. The direct request acts as soon as it goes low. It is subject to two masks: it is ignored while the power-on reset is still held low, and it is ignored while processor-only mode is selected. The same mode bit also blocks the system-reset trigger, so that the programmable domain keeps running through a processor-only reset.

A triggered clear holds the clear strobe and the pad tri-state enable for a minimum number of cycles, set by an input. The clear strobe drops first. The tri-state enable follows one cycle later. A busy flag covers the whole sequence. A new trigger that arrives during a sequence restarts the hold count; it does not queue a second sequence.

Top module: `cfg_clear_ctrl`

## Requirements
- R1: After `rst_n` is released, with all reset inputs inactive, `cfg_clear`, `io_tristate` and `busy` are all low.
- R2: A low-to-high transition of `por_n` starts a clear sequence. Holding `por_n` low, however long, starts nothing and leaves all outputs low.
- R3: A low-to-high transition of `sys_rst_n` starts a clear sequence when `sysrst_trig_en` is 1. While `sys_rst_n` is held low, no clear is started.
- R4: When `sysrst_trig_en` is 0, a low pulse on `sys_rst_n` starts no clear.
- R5: A high-to-low transition of `direct_clr_n` starts a clear. `cfg_clear` is still low after the second rising clock edge following the input change, and is high after the third.
- R6: A high-to-low transition of `direct_clr_n` while `por_n` is held low starts no clear.
- R7: While `ps_only_mode` is 1, transitions on `direct_clr_n` and `sys_rst_n` start no clear.
- R8: Once started, `cfg_clear` stays high for max(`hold_cycles`, 1) cycles. `io_tristate` is high while `cfg_clear` is high and for exactly one cycle after it. `busy` equals `io_tristate`.
- R9: A trigger that arrives while a sequence is running restarts the hold. `cfg_clear` then stays high for max(`hold_cycles`, 1) cycles counted from the new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block's own flops |
| por_n | input | 1 | Power-on reset from the processor domain, active low, asynchronous |
| sys_rst_n | input | 1 | System reset from the processor domain, active low, asynchronous |
| direct_clr_n | input | 1 | Direct configuration-clear request, active low, asynchronous |
| sysrst_trig_en | input | 1 | 1 allows the system-reset release to trigger a clear |
| ps_only_mode | input | 1 | 1 blocks the direct request and the system-reset trigger |
| hold_cycles | input | HOLD_W | Minimum cycles `cfg_clear` is held (0 is treated as 1) |
| cfg_clear | output | 1 | Configuration-clear strobe to the programmable domain |
| io_tristate | output | 1 | Tri-state enable for the programmable domain's pins |
| busy | output | 1 | High from the trigger until the sequence is back to idle |

## Verification
The hardest case to reach is a retrigger in the middle of a hold. To get there, the direct request must fall twice within one hold window, so the stimulus raises it and lowers it again two cycles apart. The expected pulse length is then the spacing plus the full hold. The masking cases come next: a direct request has to fall while the power-on reset is still low, and then be released before that reset rises. The scoreboard expects exactly one pulse in that scenario, and it must have the plain hold length.

// File: rtl/cfg_clear_pkg.sv
package cfg_clear_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_TAIL = 2'd2
    } seq_state_e;

    // bit positions inside the synchroniser bank
    localparam int IN_POR   = 0;
    localparam int IN_SYS   = 1;
    localparam int IN_DIR   = 2;
    localparam int IN_EN    = 3;
    localparam int IN_PSO   = 4;
    localparam int IN_COUNT = 5;

    // idle levels: resets released, trigger enabled, normal mode
    localparam logic [IN_COUNT-1:0] IN_IDLE = 5'b01111;

endpackage

// File: rtl/cfg_clear_sync.sv
module cfg_clear_sync #(
    parameter int         WIDTH   = 1,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_clear_trig.sv
module cfg_clear_trig
    import cfg_clear_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IN_COUNT-1:0] lvl,
    output logic                trig
);

    typedef struct packed {
        logic por;
        logic sys;
        logic dir;
    } prev_t;

    prev_t prev_d, prev_q;
    logic  por_rise, sys_rise, dir_fall;

    always_comb begin
        prev_d.por = lvl[IN_POR];
        prev_d.sys = lvl[IN_SYS];
        prev_d.dir = lvl[IN_DIR];

        por_rise = lvl[IN_POR] & ~prev_q.por;
        sys_rise = lvl[IN_SYS] & ~prev_q.sys & lvl[IN_EN] & ~lvl[IN_PSO];
        dir_fall = ~lvl[IN_DIR] & prev_q.dir & lvl[IN_POR] & ~lvl[IN_PSO];

        trig = por_rise | sys_rise | dir_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{por: 1'b1, sys: 1'b1, dir: 1'b1};
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/cfg_clear_seq.sv
module cfg_clear_seq
    import cfg_clear_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              clr,
    output logic              tri_en,
    output logic              busy
);

    typedef struct packed {
        seq_state_e        state;
        logic [HOLD_W-1:0] cnt;
    } seq_t;

    seq_t              s_d, s_q;
    logic [HOLD_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (hold_cycles == '0) ? '0 : hold_cycles - 1'b1;
        s_d      = s_q;
        if (trig) begin
            s_d.state = SQ_HOLD;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.state)
                SQ_HOLD: begin
                    if (s_q.cnt >= last_cnt) s_d.state = SQ_TAIL;
                    else                     s_d.cnt   = s_q.cnt + 1'b1;
                end
                SQ_TAIL: s_d.state = SQ_IDLE;
                default: s_d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SQ_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign clr    = (s_q.state == SQ_HOLD);
    assign tri_en = (s_q.state != SQ_IDLE);
    assign busy   = tri_en;

endmodule

// File: rtl/cfg_clear_ctrl.sv
module cfg_clear_ctrl
    import cfg_clear_pkg::*;
#(
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              direct_clr_n,
    input  logic              sysrst_trig_en,
    input  logic              ps_only_mode,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              cfg_clear,
    output logic              io_tristate,
    output logic              busy
);

    logic [IN_COUNT-1:0] raw_in;
    logic [IN_COUNT-1:0] lvl;
    logic                trig_any;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_POR]  = por_n;
        raw_in[IN_SYS]  = sys_rst_n;
        raw_in[IN_DIR]  = direct_clr_n;
        raw_in[IN_EN]   = sysrst_trig_en;
        raw_in[IN_PSO]  = ps_only_mode;
    end

    cfg_clear_sync #(
        .WIDTH  (IN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_in),
        .sync_out(lvl)
    );

    cfg_clear_trig u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .trig (trig_any)
    );

    cfg_clear_seq #(
        .HOLD_W(HOLD_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig_any),
        .hold_cycles(hold_cycles),
        .clr        (cfg_clear),
        .tri_en     (io_tristate),
        .busy       (busy)
    );

endmodule

// File: rtl/cfg_clear_ctrl_chk.sv
module cfg_clear_ctrl_chk #(
    parameter int HOLD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic [HOLD_W-1:0] hold_cycles,
    input logic              cfg_clear,
    input logic              io_tristate,
    input logic              busy
);

    logic [HOLD_W:0] run_q;
    logic [HOLD_W:0] eff_hold;

    assign eff_hold = (hold_cycles == '0) ? 1 : {1'b0, hold_cycles};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_q <= '0;
        else if (trig)       run_q <= '0;
        else if (cfg_clear)  run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    assert_clear_under_tri_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |-> io_tristate);

    assert_tri_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clear) |-> io_tristate);

    assert_busy_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy == io_tristate);

    assert_hold_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |-> (run_q < eff_hold));

    assert_trig_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cfg_clear && busy));

    assert_no_spontaneous_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> !busy);

endmodule

bind cfg_clear_ctrl cfg_clear_ctrl_chk #(.HOLD_W(HOLD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig_any),
    .hold_cycles(hold_cycles),
    .cfg_clear  (cfg_clear),
    .io_tristate(io_tristate),
    .busy       (busy)
);

// File: tb/tb_cfg_clear_ctrl.sv
module tb_cfg_clear_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HW         = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          por_n, sys_rst_n, direct_clr_n, sysrst_trig_en, ps_only_mode;
    logic [HW-1:0] hold_cycles;
    logic          cfg_clear, io_tristate, busy;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int pushed = 0;
    int seen = 0;

    cfg_clear_ctrl #(.HOLD_W(HW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .por_n         (por_n),
        .sys_rst_n     (sys_rst_n),
        .direct_clr_n  (direct_clr_n),
        .sysrst_trig_en(sysrst_trig_en),
        .ps_only_mode  (ps_only_mode),
        .hold_cycles   (hold_cycles),
        .cfg_clear     (cfg_clear),
        .io_tristate   (io_tristate),
        .busy          (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_pulse(input int len);
        exp_q.push_back(len);
        pushed++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input string req);
        idle(40);
        chk(seen == pushed, req, seen, pushed);
        chk(busy == 1'b0 && io_tristate == 1'b0, req, {busy, io_tristate}, 0);
    endtask

    // monitor: measures each clear pulse and checks it against the queue
    int  run_len   = 0;
    bit  in_pulse  = 0;
    bit  tail_chk  = 0;
    bit  ok_during = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tail_chk) begin
                tail_chk = 0;
                chk(io_tristate == 1'b0 && busy == 1'b0, "R8 tail end",
                    {busy, io_tristate}, 0);
            end
            if (cfg_clear) begin
                run_len++;
                in_pulse = 1;
                if (!(io_tristate && busy)) ok_during = 0;
            end else if (in_pulse) begin
                seen++;
                chk(ok_during && io_tristate && busy, "R8 tri/busy cover",
                    {ok_during, io_tristate, busy}, 7);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2-R9 unexpected pulse", run_len, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(run_len == e, "R8/R9 pulse length", run_len, e);
                end
                in_pulse  = 0;
                run_len   = 0;
                ok_during = 1;
                tail_chk  = 1;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_n = 1'b1; sys_rst_n = 1'b1; direct_clr_n = 1'b1;
        sysrst_trig_en = 1'b1; ps_only_mode = 1'b0; hold_cycles = 8'd10;
        idle(3);
        rst_n = 1'b1;
        idle(5);
        chk(!cfg_clear && !io_tristate && !busy, "R1 reset state",
            {cfg_clear, io_tristate, busy}, 0);

        // R5: direct request, latency and default hold
        expect_pulse(10);
        direct_clr_n = 1'b0;
        idle(2);
        chk(cfg_clear == 1'b0, "R5 not before third edge", cfg_clear, 0);
        idle(1);
        chk(cfg_clear == 1'b1, "R5 high after third edge", cfg_clear, 1);
        direct_clr_n = 1'b1;
        settle("R5");

        // R8: short hold and zero hold
        hold_cycles = 8'd3;
        expect_pulse(3);
        direct_clr_n = 1'b0; idle(3); direct_clr_n = 1'b1;
        settle("R8 hold 3");
        hold_cycles = 8'd0;
        expect_pulse(1);
        direct_clr_n = 1'b0; idle(3); direct_clr_n = 1'b1;
        settle("R8 hold 0");
        hold_cycles = 8'd10;

        // R9: second trigger four cycles into the hold
        expect_pulse(14);
        direct_clr_n = 1'b0; idle(2); direct_clr_n = 1'b1; idle(2);
        direct_clr_n = 1'b0; idle(2); direct_clr_n = 1'b1;
        settle("R9 restart");

        // R2: power-on reset held low does nothing, release clears
        por_n = 1'b0;
        idle(20);
        chk(!cfg_clear && !busy, "R2 held low", {cfg_clear, busy}, 0);
        expect_pulse(10);
        por_n = 1'b1;
        settle("R2 release");

        // R6: direct request masked while power-on reset low
        por_n = 1'b0; idle(5);
        direct_clr_n = 1'b0; idle(5); direct_clr_n = 1'b1; idle(5);
        chk(!busy && !cfg_clear, "R6 masked", {busy, cfg_clear}, 0);
        expect_pulse(10);
        por_n = 1'b1;
        settle("R6");

        // R3: system reset clears on release only
        sys_rst_n = 1'b0;
        idle(20);
        chk(!busy && !cfg_clear, "R3 nothing while low", {busy, cfg_clear}, 0);
        expect_pulse(10);
        sys_rst_n = 1'b1;
        settle("R3 release");

        // R4: trigger enable off
        sysrst_trig_en = 1'b0; idle(5);
        sys_rst_n = 1'b0; idle(10); sys_rst_n = 1'b1;
        settle("R4 disabled");
        sysrst_trig_en = 1'b1; idle(5);

        // R7: processor-only mode blocks both
        ps_only_mode = 1'b1; idle(5);
        sys_rst_n = 1'b0; idle(10); sys_rst_n = 1'b1; idle(5);
        direct_clr_n = 1'b0; idle(10); direct_clr_n = 1'b1;
        settle("R7 blocked");
        ps_only_mode = 1'b0; idle(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule